// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where subroutine returns will go. It does not look at the fetch address. It decodes the newest instruction that enters the instruction fetch buffer. A call-type instruction makes it save the address of the following instruction in a small circular stack of halfword addresses. A return-type instruction makes it pop the most recent saved address and use it as the next fetch target. In that cycle it also rewrites the prediction-info field of the buffer entry that holds the return.

Both 32-bit and 16-bit compressed encodings are recognised, so a saved address can be halfword aligned. Fetch is always word aligned, so the block splits a target into a word-aligned fetch address and a flag that marks a halfword target. A halfword target costs one extra fetch cycle. A prediction from this block wins over a prediction from the table-based predictor. The chosen target leaves through the same push interface toward the buffer of predictions. A prediction is made only when that buffer can accept an entry.

Top module: `ras_predictor`

## Requirements
- R1: When `ifb_push` is 1 and the instruction is a 32-bit JAL (opcode 1101111) or a JALR (opcode 1100111, funct3 000) whose rd (bits 11:7) is x1 or x5, the stack records the instruction address plus 4.
- R2: When `ifb_push` is 1 and the instruction is a compressed call, the stack records the instruction address plus 2. A compressed instruction has bits 1:0 not equal to 11. The compressed calls are C.JAL (bits 15:13 = 001, bits 1:0 = 01) and C.JALR (bits 15:12 = 1001, bits 11:7 nonzero, bits 6:2 zero, bits 1:0 = 10).
- R3: A return is recognised in two forms: a 32-bit JALR with rd x0, rs1 (bits 19:15) x1 or x5 and an immediate (bits 31:20) of zero, or a C.JR (bits 15:12 = 1000, bits 6:2 zero, bits 1:0 = 10) with rs1 (bits 11:7) x1 or x5. On a return the block predicts the most recently recorded address, which is then removed (last in, first out), in the same cycle as `ifb_push`.
- R4: A return seen while the stack is empty produces no prediction and leaves the stack unchanged.
- R5: The stack holds 4 entries. A call made while the stack is full overwrites the oldest entry, so only the 4 newest addresses can be predicted.
- R6: No return prediction is made while `bop_ready` is 0, and the stack is not popped in that cycle.
- R7: On a return prediction, `info_wr_en` is 1 and `info_wr_data` is 2'b11 (bit 0 = predicted taken, bit 1 = made by the return stack). Otherwise both are 0.
- R8: A return prediction takes priority over `tbl_valid`/`tbl_target`. Without one, a table prediction passes through to `bop_target` unchanged. `bop_push` and `fetch_redirect` are 1 whenever either prediction is present.
- R9: On a redirect, `fetch_addr` is the target with bits 1:0 cleared, and `fetch_half` equals bit 1 of the target.
- R10: Instructions that are neither calls nor returns leave the stack unchanged. Examples are JALR x0 via x2, JALR x0 via x1 with a nonzero immediate, C.EBREAK, and JAL x0.
- R11: While `ifb_push` is 0 the instruction and address inputs have no effect.
- R12: After reset the stack is empty and no return prediction is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifb_push | input | 1 | A new instruction enters the fetch buffer this cycle |
| ifb_pc_h | input | 31 | Halfword address (bits 31:1) of that instruction |
| ifb_instr | input | 32 | Instruction bits; a compressed one sits in bits 15:0 |
| bop_ready | input | 1 | Buffer of predictions has room for one target |
| tbl_valid | input | 1 | Table-based predictor has a prediction |
| tbl_target | input | 32 | Table-based predicted target |
| info_wr_en | output | 1 | Rewrite the newest fetch-buffer entry's prediction info |
| info_wr_data | output | 2 | New prediction info value |
| bop_push | output | 1 | Push `bop_target` into the buffer of predictions |
| bop_target | output | 32 | Selected predicted target |
| fetch_redirect | output | 1 | Next fetch goes to the predicted target |
| fetch_addr | output | 32 | Word-aligned next fetch address |
| fetch_half | output | 1 | Target is halfword aligned (one extra fetch cycle) |

## Verification
The assertions assume that a table prediction arrives already gated by the table predictor's own check for room in the buffer of predictions. They also assume that `ifb_push` stays low during reset, so that no call or return is decoded before the stack is live. The bench drives instructions only from encoding builders whose kind is known in advance. It holds `ifb_push` at 0 throughout reset, and it raises `tbl_valid` only in cycles set aside to test priority. The reference model therefore follows the stack from the declared kind of each instruction, never from decoding the bits.

// File: rtl/ras_pkg.sv
package ras_pkg;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned INFO_W = 2;

  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;

  // prediction info written into the newest fetch-buffer entry
  localparam logic [INFO_W-1:0] INFO_RAS_TAKEN = 2'b11;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CALL = 2'd1,
    KIND_RET  = 2'd2
  } ctl_kind_e;

  typedef struct packed {
    ctl_kind_e kind;
    logic      short_op;  // 16-bit encoding
  } ctl_dec_t;

  function automatic logic is_link_reg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

endpackage

// File: rtl/ras_decoder.sv
module ras_decoder
  import ras_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output ctl_dec_t        dec
);

  logic [4:0] rd_w;
  logic [4:0] rs1_w;
  logic [4:0] rs_c;

  assign rd_w  = instr[11:7];
  assign rs1_w = instr[19:15];
  assign rs_c  = instr[11:7];

  always_comb begin
    dec.kind     = KIND_NONE;
    dec.short_op = (instr[1:0] != 2'b11);
    if (!dec.short_op) begin
      if (instr[6:0] == OPC_JAL) begin
        if (is_link_reg(rd_w)) dec.kind = KIND_CALL;
      end else if (instr[6:0] == OPC_JALR && instr[14:12] == 3'b000) begin
        if (is_link_reg(rd_w)) begin
          dec.kind = KIND_CALL;
        end else if (rd_w == 5'd0 && is_link_reg(rs1_w) && instr[31:20] == 12'd0) begin
          dec.kind = KIND_RET;
        end
      end
    end else begin
      if (instr[1:0] == 2'b01 && instr[15:13] == 3'b001) begin
        dec.kind = KIND_CALL;
      end else if (instr[1:0] == 2'b10 && instr[6:2] == 5'd0 && rs_c != 5'd0) begin
        if (instr[15:12] == 4'b1001) begin
          dec.kind = KIND_CALL;
        end else if (instr[15:12] == 4'b1000 && is_link_reg(rs_c)) begin
          dec.kind = KIND_RET;
        end
      end
    end
  end

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_en,
  input  logic [XLEN-1:1]         push_data,
  input  logic                    pop_en,
  output logic [XLEN-1:1]         top_data,
  output logic                    empty,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [PW-1:0] ptr_q, ptr_d;      // next free slot
  logic [PW-1:0] ptr_up, ptr_dn;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [XLEN-1:1] slots [DEPTH];

  assign ptr_up = (ptr_q == LAST_IDX) ? '0 : ptr_q + PW'(1);
  assign ptr_dn = (ptr_q == '0) ? LAST_IDX : ptr_q - PW'(1);

  // next state
  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (push_en) begin
      ptr_d = ptr_up;
      if (cnt_q != FULL_CNT) cnt_d = cnt_q + CW'(1);
    end else if (pop_en && cnt_q != '0) begin
      ptr_d = ptr_dn;
      cnt_d = cnt_q - CW'(1);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  // storage: one register per slot with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic            wr_en;
    logic [XLEN-1:1] val_q;
    assign wr_en = push_en && (ptr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (wr_en) val_q <= push_data;
    end
    assign slots[i] = val_q;
  end

  assign top_data = slots[ptr_dn];
  assign empty    = (cnt_q == '0);
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/ras_redirect.sv
module ras_redirect #(
  parameter int unsigned XLEN = 32
) (
  input  logic            ras_hit,
  input  logic [XLEN-1:1] ras_target,
  input  logic            tbl_valid,
  input  logic [XLEN-1:0] tbl_target,
  output logic            redirect,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] word_addr,
  output logic            half
);

  always_comb begin
    if (ras_hit) target = {ras_target, 1'b0};
    else         target = tbl_target;
    redirect  = ras_hit || tbl_valid;
    word_addr = {target[XLEN-1:2], 2'b00};
    half      = redirect && target[1];
  end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
  import ras_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifb_push,
  input  logic [XLEN-1:1]   ifb_pc_h,
  input  logic [ILEN-1:0]   ifb_instr,
  input  logic              bop_ready,
  input  logic              tbl_valid,
  input  logic [XLEN-1:0]   tbl_target,
  output logic              info_wr_en,
  output logic [INFO_W-1:0] info_wr_data,
  output logic              bop_push,
  output logic [XLEN-1:0]   bop_target,
  output logic              fetch_redirect,
  output logic [XLEN-1:0]   fetch_addr,
  output logic              fetch_half
);

  localparam int unsigned     CW     = $clog2(DEPTH + 1);
  localparam logic [XLEN-1:1] STEP_C = (XLEN-1)'(1);  // 2 bytes
  localparam logic [XLEN-1:1] STEP_W = (XLEN-1)'(2);  // 4 bytes

  ctl_dec_t        dec;
  logic            call_seen;
  logic            ret_seen;
  logic            ras_hit;
  logic [XLEN-1:1] link_addr;
  logic [XLEN-1:1] ras_target;
  logic            stk_empty;
  logic [CW-1:0]   stk_cnt;

  ras_decoder u_dec (
    .instr (ifb_instr),
    .dec   (dec)
  );

  assign call_seen = ifb_push && (dec.kind == KIND_CALL);
  assign ret_seen  = ifb_push && (dec.kind == KIND_RET);
  assign ras_hit   = ret_seen && !stk_empty && bop_ready;
  assign link_addr = ifb_pc_h + (dec.short_op ? STEP_C : STEP_W);

  ras_stack #(
    .XLEN  (XLEN),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (call_seen),
    .push_data (link_addr),
    .pop_en    (ras_hit),
    .top_data  (ras_target),
    .empty     (stk_empty),
    .cnt_o     (stk_cnt)
  );

  ras_redirect #(
    .XLEN (XLEN)
  ) u_redir (
    .ras_hit    (ras_hit),
    .ras_target (ras_target),
    .tbl_valid  (tbl_valid),
    .tbl_target (tbl_target),
    .redirect   (fetch_redirect),
    .target     (bop_target),
    .word_addr  (fetch_addr),
    .half       (fetch_half)
  );

  assign bop_push     = fetch_redirect;
  assign info_wr_en   = ras_hit;
  assign info_wr_data = ras_hit ? INFO_RAS_TAKEN : '0;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bop_ready,
  input logic                        ras_hit,
  input logic                        stk_empty,
  input logic [$clog2(DEPTH+1)-1:0]  stk_cnt,
  input logic                        push_en,
  input logic [XLEN-1:1]             push_data,
  input logic                        pop_en,
  input logic [XLEN-1:1]             ras_target,
  input logic                        tbl_valid,
  input logic [XLEN-1:0]             tbl_target,
  input logic                        info_wr_en,
  input logic                        bop_push,
  input logic [XLEN-1:0]             bop_target,
  input logic                        fetch_redirect,
  input logic [XLEN-1:0]             fetch_addr,
  input logic                        fetch_half
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CW'(DEPTH));

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && stk_cnt < CW'(DEPTH)) |=> (stk_cnt == $past(stk_cnt) + CW'(1)));

  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_empty |-> !ras_hit);

  p_bop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bop_ready |-> !ras_hit);

  p_lifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_en ##1 pop_en |-> (ras_target == $past(push_data)));

  p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_hit |-> (info_wr_en && bop_push));

  p_ras_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ras_hit |-> (bop_target == {ras_target, 1'b0}));

  p_table_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_hit && tbl_valid) |-> (bop_target == tbl_target));

  p_word_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |-> (fetch_addr[1:0] == 2'b00 &&
                        fetch_addr[XLEN-1:2] == bop_target[XLEN-1:2] &&
                        fetch_half == bop_target[1]));

endmodule

bind ras_predictor ras_checker #(
  .XLEN  (XLEN),
  .DEPTH (DEPTH)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bop_ready      (bop_ready),
  .ras_hit        (ras_hit),
  .stk_empty      (stk_empty),
  .stk_cnt        (stk_cnt),
  .push_en        (call_seen),
  .push_data      (link_addr),
  .pop_en         (ras_hit),
  .ras_target     (ras_target),
  .tbl_valid      (tbl_valid),
  .tbl_target     (tbl_target),
  .info_wr_en     (info_wr_en),
  .bop_push       (bop_push),
  .bop_target     (bop_target),
  .fetch_redirect (fetch_redirect),
  .fetch_addr     (fetch_addr),
  .fetch_half     (fetch_half)
);

// File: tb/tb_ras_predictor.sv
`timescale 1ns/1ps
module tb_ras_predictor;

  localparam int KN = 0;  // neither call nor return
  localparam int KC = 1;  // call
  localparam int KR = 2;  // return

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ifb_push;
  logic [31:1] ifb_pc_h;
  logic [31:0] ifb_instr;
  logic        bop_ready;
  logic        tbl_valid;
  logic [31:0] tbl_target;
  logic        info_wr_en;
  logic [1:0]  info_wr_data;
  logic        bop_push;
  logic [31:0] bop_target;
  logic        fetch_redirect;
  logic [31:0] fetch_addr;
  logic        fetch_half;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int unsigned model_q[$];  // newest at the back

  always #2.5 clk = ~clk;

  ras_predictor dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .ifb_push       (ifb_push),
    .ifb_pc_h       (ifb_pc_h),
    .ifb_instr      (ifb_instr),
    .bop_ready      (bop_ready),
    .tbl_valid      (tbl_valid),
    .tbl_target     (tbl_target),
    .info_wr_en     (info_wr_en),
    .info_wr_data   (info_wr_data),
    .bop_push       (bop_push),
    .bop_target     (bop_target),
    .fetch_redirect (fetch_redirect),
    .fetch_addr     (fetch_addr),
    .fetch_half     (fetch_half)
  );

  // instruction builders
  function automatic logic [31:0] i_jal(input logic [4:0] rd);
    return {20'h00010, rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] i_jalr(input logic [4:0] rd, input logic [4:0] rs1,
                                         input logic [11:0] imm);
    return {imm, rs1, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] c_jal();
    return {16'hBEEF, 3'b001, 11'h155, 2'b01};
  endfunction
  function automatic logic [31:0] c_jalr(input logic [4:0] rs);
    return {16'hA5A5, 4'b1001, rs, 5'd0, 2'b10};
  endfunction
  function automatic logic [31:0] c_jr(input logic [4:0] rs);
    return {16'h5A5A, 4'b1000, rs, 5'd0, 2'b10};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [31:0] pc,
                      input logic [31:0] ins, input int kind, input logic cmp,
                      input logic br, input logic tv, input logic [31:0] tt);
    logic        e_hit;
    logic [31:0] e_tgt;
    @(negedge clk);
    ifb_push   = v;
    ifb_pc_h   = pc[31:1];
    ifb_instr  = ins;
    bop_ready  = br;
    tbl_valid  = tv;
    tbl_target = tt;
    #1;
    e_hit = v && kind == KR && model_q.size() > 0 && br;
    e_tgt = e_hit ? model_q[$] : tt;
    chk(tag, "redirect",   {31'd0, fetch_redirect}, {31'd0, e_hit || tv});
    chk(tag, "bop_push",   {31'd0, bop_push},       {31'd0, e_hit || tv});
    chk(tag, "info_en",    {31'd0, info_wr_en},     {31'd0, e_hit});
    chk(tag, "info_data",  {30'd0, info_wr_data},   e_hit ? 32'd3 : 32'd0);
    if (e_hit || tv) begin
      chk(tag, "target",     bop_target, e_tgt);
      chk(tag, "fetch_addr", fetch_addr, {e_tgt[31:2], 2'b00});
      chk(tag, "fetch_half", {31'd0, fetch_half}, {31'd0, e_tgt[1]});
    end
    if (v && kind == KC) begin
      if (model_q.size() == 4) void'(model_q.pop_front());
      model_q.push_back(pc + (cmp ? 32'd2 : 32'd4));
    end
    if (e_hit) void'(model_q.pop_back());
  endtask

  task automatic idle();
    step("idle", 1'b0, 32'h0, 32'h0, KN, 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ifb_push = 1'b0; ifb_pc_h = '0; ifb_instr = '0;
    bop_ready = 1'b1; tbl_valid = 1'b0; tbl_target = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "reset redirect", {31'd0, fetch_redirect}, 32'd0);
    chk("R12", "reset info_en",  {31'd0, info_wr_en},     32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R12 / R4: return right after reset predicts nothing
    step("R12", 1'b1, 32'h80, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R1: 32-bit calls, R3: 32-bit and compressed returns (LIFO)
    step("R1", 1'b1, 32'h100, i_jal(5'd1), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R1", 1'b1, 32'h200, i_jalr(5'd5, 5'd6, 12'h010), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R3", 1'b1, 32'h300, i_jalr(5'd0, 5'd1, 12'h000), KR, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R3", 1'b1, 32'h308, c_jr(5'd5), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R2: compressed calls, halfword targets (R9)
    step("R2", 1'b1, 32'h2000, c_jal(), KC, 1'b1, 1'b1, 1'b0, 32'h0);
    step("R2", 1'b1, 32'h2010, c_jalr(5'd7), KC, 1'b1, 1'b1, 1'b0, 32'h0);
    step("R9", 1'b1, 32'h2100, i_jalr(5'd0, 5'd5, 12'h000), KR, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R9", 1'b1, 32'h2104, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R4: stack is empty again
    step("R4", 1'b1, 32'h2200, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R6: no room in buffer of predictions
    step("R6", 1'b1, 32'h400, i_jal(5'd5), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R6", 1'b1, 32'h410, c_jr(5'd1), KR, 1'b1, 1'b0, 1'b0, 32'h0);
    step("R6", 1'b1, 32'h414, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R5: overflow drops the oldest
    for (int i = 1; i <= 5; i++)
      step("R5", 1'b1, 32'h10 * i, i_jal(5'd1), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    for (int i = 0; i < 5; i++)
      step("R5", 1'b1, 32'h900 + 4 * i, i_jalr(5'd0, 5'd1, 12'h0), KR, 1'b0, 1'b1, 1'b0, 32'h0);

    // R10: look-alikes leave the stack untouched
    step("R10", 1'b1, 32'h600, i_jal(5'd1), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 32'h610, i_jalr(5'd0, 5'd2, 12'h0), KN, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 32'h614, i_jalr(5'd0, 5'd1, 12'h004), KN, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 32'h618, 32'h0000_9002, KN, 1'b1, 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 32'h61c, i_jal(5'd0), KN, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 32'h620, 32'h0010_0093, KN, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 32'h624, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R11: inputs ignored without ifb_push
    step("R11", 1'b1, 32'h700, i_jal(5'd1), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R11", 1'b0, 32'h800, i_jal(5'd1), KC, 1'b0, 1'b1, 1'b0, 32'h0);
    step("R11", 1'b0, 32'h804, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);
    step("R11", 1'b1, 32'h808, c_jr(5'd1), KR, 1'b1, 1'b1, 1'b0, 32'h0);

    // R8: table pass-through and return-stack priority; R7 override checked on every hit
    step("R8", 1'b0, 32'h0, 32'h0, KN, 1'b0, 1'b1, 1'b1, 32'h0000_1236);
    step("R8", 1'b1, 32'hA00, c_jal(), KC, 1'b1, 1'b1, 1'b1, 32'h0000_4000);
    step("R8", 1'b1, 32'hB00, c_jr(5'd5), KR, 1'b1, 1'b1, 1'b1, 32'h0000_5550);
    step("R7", 1'b1, 32'hB04, c_jr(5'd5), KR, 1'b1, 1'b1, 1'b1, 32'h0000_7770);
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule